// File: doc/BRIEF.md
# DRAM Initialization Mode Command Generator

This block sits between a host memory-access port and a DDR2 command pin set. A 3-bit mode field, written by software, decides what a host access does. In the four forcing modes, each host access becomes exactly one fixed DRAM command: NOP, precharge of all banks, mode-register load, or auto refresh. Software can then step the memory through its power-up sequence using ordinary accesses. In normal mode, accesses pass straight through to a downstream scheduler port.

The block owns the clock-enable lines of every rank. They are low during reset and stay low after reset until software writes a non-zero mode. When a low-power request arrives, the block first waits for downstream traffic to drain. It then puts all ranks into self-refresh. When the request drops, it wakes the ranks with no software involvement. A read-only memory-type field mirrors a board strap.

Top module: `dram_init_cmdgen`

## Requirements
- R1: While reset is asserted and right after it, the mode reads 000, every clock-enable is low, the command pins idle at NOP (CS#,RAS#,CAS#,WE# = 0111), and no acknowledge is given.
- R2: Clock-enables stay low after reset until a mode write of a value other than 000. From the cycle after that write they are all high together, and later writes (including 000) do not lower them.
- R3: In mode 001 each host access issues one NOP (0111) and gets a one-cycle acknowledge in the same cycle the command appears.
- R4: In mode 010 each host access issues precharge (0010) with DRAM address bit 10 high and all other address bits low.
- R5: In mode 011 each host access issues mode-register load (0000). DRAM address [9:0] takes host address [12:3], DRAM address bit 11 takes host bit 13, every other address bit is 0, and the bank address takes host bits [15:14].
- R6: In mode 110 each host access issues auto refresh (0001) with a zero address.
- R7: In modes 000, 100 and 101 a host access is acknowledged for one cycle and the pins stay at NOP with a zero address.
- R8: In mode 111 the host request and address appear on the forward port, and the host acknowledge follows the downstream acknowledge. No DRAM command is forced.
- R9: The memory-type output always equals the 2-bit strap input. The value 10 denotes DDR2 and the other values are reserved.
- R10: While a low-power request is high, no host access is accepted. Once the pending-traffic input is low, a refresh command (0001) is issued in the same cycle that all clock-enables go low, and they stay low while the request is held.
- R11: When the low-power request drops, the clock-enables rise on the next cycle. The pins then hold NOP for EXIT_NOPS cycles, and only after that is a host access accepted.
- R12: The mode output reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_wdata | input | 3 | Mode value to write |
| mode_rd | output | 3 | Current mode |
| strap_type | input | 2 | Memory-type strap |
| mem_type | output | 2 | Read-only memory type |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_addr | input | HA_W | Host access address |
| host_ack | output | 1 | Host access acknowledge |
| fwd_req | output | 1 | Request to the downstream scheduler (mode 111) |
| fwd_addr | output | HA_W | Address to the downstream scheduler |
| fwd_ack | input | 1 | Downstream acknowledge |
| lp_req | input | 1 | Low-power request, level sensitive |
| pend_busy | input | 1 | Downstream still has pending commands |
| dram_cke | output | RANKS | Clock-enable, one per rank |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ROW_W | DRAM address |
| dram_ba | output | 2 | DRAM bank address |

## Verification
The assertions assume that a host request, once raised, stays up with a stable address until the acknowledge is seen. They also assume the mode is not rewritten while an access is outstanding. The address-mapping property relies on both of these. The bench drives every input a quarter period after the falling edge and drops each request as soon as the acknowledge is sampled. It changes the mode only between accesses, and it raises the low-power request only with no access in flight.

// File: rtl/dicg_pkg.sv
package dicg_pkg;

  typedef enum logic [2:0] {
    MD_RESET  = 3'b000,
    MD_NOP    = 3'b001,
    MD_PREALL = 3'b010,
    MD_LOADMR = 3'b011,
    MD_RSV4   = 3'b100,
    MD_RSV5   = 3'b101,
    MD_REFR   = 3'b110,
    MD_RUN    = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    LP_RUN,
    LP_DRAIN,
    LP_SLEEP,
    LP_WAKE
  } lp_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_PRE = 4'b0010;
  localparam logic [3:0] PIN_LMR = 4'b0000;
  localparam logic [3:0] PIN_REF = 4'b0001;

  function automatic logic mode_forces(input mode_e m);
    return (m == MD_NOP) || (m == MD_PREALL) || (m == MD_LOADMR) || (m == MD_REFR);
  endfunction

  function automatic logic [3:0] mode_pins(input mode_e m);
    case (m)
      MD_PREALL: return PIN_PRE;
      MD_LOADMR: return PIN_LMR;
      MD_REFR:   return PIN_REF;
      default:   return PIN_NOP;
    endcase
  endfunction

endpackage

// File: rtl/dicg_mode_reg.sv
module dicg_mode_reg
  import dicg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_wdata,
  output mode_e      mode_q,
  output logic       cke_armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_RESET;
      cke_armed <= 1'b0;
    end else if (cfg_wr) begin
      mode_q <= mode_e'(cfg_wdata);
      if (cfg_wdata != 3'b000) cke_armed <= 1'b1;
    end
  end

endmodule

// File: rtl/dicg_lp_seq.sv
module dicg_lp_seq
  import dicg_pkg::*;
#(
  parameter int EXIT_NOPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_req,
  input  logic pend_busy,
  output lp_e  state_q,
  output logic sleep_enter
);

  localparam int CW = $clog2(EXIT_NOPS + 1);
  localparam logic [CW-1:0] LAST = CW'(EXIT_NOPS - 1);

  logic [CW-1:0] cnt_q;

  assign sleep_enter = (state_q == LP_DRAIN) && !pend_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LP_RUN;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        LP_RUN:   if (lp_req) state_q <= LP_DRAIN;
        LP_DRAIN: if (!pend_busy) state_q <= LP_SLEEP;
        LP_SLEEP: if (!lp_req) begin
          state_q <= LP_WAKE;
          cnt_q   <= '0;
        end
        LP_WAKE: begin
          if (cnt_q == LAST) state_q <= LP_RUN;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= LP_RUN;
      endcase
    end
  end

endmodule

// File: rtl/dicg_cmd_gen.sv
module dicg_cmd_gen
  import dicg_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             sleep_enter,
  input  mode_e            mode,
  input  logic [12:0]      ha_hi,    // host address bits [15:3]
  output logic [3:0]       pins_q,
  output logic [ROW_W-1:0] addr_q,
  output logic [1:0]       ba_q,
  output logic             ack_q
);

  function automatic logic [ROW_W-1:0] row_for(input mode_e m, input logic [12:0] h);
    logic [ROW_W-1:0] a;
    a = '0;
    if (m == MD_PREALL) a[10] = 1'b1;
    if (m == MD_LOADMR) begin
      a[9:0] = h[9:0];
      a[11]  = h[10];
    end
    return a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= PIN_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      ack_q  <= 1'b0;
    end else if (sleep_enter) begin
      pins_q <= PIN_REF;
      addr_q <= '0;
      ba_q   <= '0;
      ack_q  <= 1'b0;
    end else if (issue) begin
      pins_q <= mode_pins(mode);
      addr_q <= row_for(mode, ha_hi);
      ba_q   <= (mode == MD_LOADMR) ? ha_hi[12:11] : 2'b00;
      ack_q  <= 1'b1;
    end else begin
      pins_q <= PIN_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      ack_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/dram_init_cmdgen.sv
module dram_init_cmdgen
  import dicg_pkg::*;
#(
  parameter int HA_W      = 32,
  parameter int ROW_W     = 14,
  parameter int RANKS     = 2,
  parameter int EXIT_NOPS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_wdata,
  output logic [2:0]       mode_rd,
  input  logic [1:0]       strap_type,
  output logic [1:0]       mem_type,
  input  logic             host_req,
  input  logic [HA_W-1:0]  host_addr,
  output logic             host_ack,
  output logic             fwd_req,
  output logic [HA_W-1:0]  fwd_addr,
  input  logic             fwd_ack,
  input  logic             lp_req,
  input  logic             pend_busy,
  output logic [RANKS-1:0] dram_cke,
  output logic             dram_cs_n,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic [ROW_W-1:0] dram_addr,
  output logic [1:0]       dram_ba
);

  mode_e      mode_q;
  lp_e        lp_state;
  logic       ev_cke_armed;
  logic       ev_sleep_enter;
  logic       ev_issue;
  logic       ev_ack_q;
  logic       ev_run;
  logic       ev_wake;
  logic       ev_asleep;
  logic [3:0] pins;

  dicg_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .mode_q    (mode_q),
    .cke_armed (ev_cke_armed)
  );

  dicg_lp_seq #(.EXIT_NOPS(EXIT_NOPS)) u_lp (
    .clk         (clk),
    .rst_n       (rst_n),
    .lp_req      (lp_req),
    .pend_busy   (pend_busy),
    .state_q     (lp_state),
    .sleep_enter (ev_sleep_enter)
  );

  assign ev_run    = (lp_state == LP_RUN) && !lp_req;
  assign ev_wake   = (lp_state == LP_WAKE);
  assign ev_asleep = (lp_state == LP_SLEEP);
  assign ev_issue  = host_req && ev_run && !ev_ack_q && (mode_q != MD_RUN);

  dicg_cmd_gen #(.ROW_W(ROW_W)) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (ev_issue),
    .sleep_enter (ev_sleep_enter),
    .mode        (mode_q),
    .ha_hi       (host_addr[15:3]),
    .pins_q      (pins),
    .addr_q      (dram_addr),
    .ba_q        (dram_ba),
    .ack_q       (ev_ack_q)
  );

  assign fwd_req  = host_req && ev_run && (mode_q == MD_RUN);
  assign fwd_addr = host_addr;
  assign host_ack = ev_ack_q || (fwd_req && fwd_ack);

  assign dram_cke = {RANKS{ev_cke_armed && !ev_asleep}};
  assign {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} = pins;

  assign mode_rd  = mode_q;
  assign mem_type = strap_type;

endmodule

// File: rtl/dicg_chk.sv
module dicg_chk
  import dicg_pkg::*;
#(
  parameter int RANKS = 2,
  parameter int ROW_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RANKS-1:0] dram_cke,
  input logic [3:0]       pins,
  input logic [ROW_W-1:0] dram_addr,
  input logic [15:0]      ha_lo,
  input logic [2:0]       mode_rd,
  input logic             fwd_req,
  input logic             host_ack,
  input logic             ev_cke_armed,
  input logic             ev_issue,
  input logic             ev_ack_q,
  input logic             ev_run,
  input logic             ev_wake
);

  p_cke_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cke != '0) |-> ev_cke_armed);

  p_cke_together_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cke == '0) || (dram_cke == '1));

  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_q |=> !ev_ack_q);

  p_issue_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> host_ack);

  p_lmr_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack_q && pins == PIN_LMR) |->
      (dram_addr[9:0] == $past(ha_lo[12:3]) && dram_addr[11] == $past(ha_lo[13])));

  p_fwd_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_req |-> (mode_rd == 3'b111));

  p_sleep_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cke[0]) |-> (pins == PIN_REF));

  p_hold_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_run |-> (!fwd_req && !ev_issue));

  p_wake_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake |-> (pins == PIN_NOP && (dram_cke == '1 || !ev_cke_armed)));

endmodule

bind dram_init_cmdgen dicg_chk #(.RANKS(RANKS), .ROW_W(ROW_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dram_cke     (dram_cke),
  .pins         (pins),
  .dram_addr    (dram_addr),
  .ha_lo        (host_addr[15:0]),
  .mode_rd      (mode_rd),
  .fwd_req      (fwd_req),
  .host_ack     (host_ack),
  .ev_cke_armed (ev_cke_armed),
  .ev_issue     (ev_issue),
  .ev_ack_q     (ev_ack_q),
  .ev_run       (ev_run),
  .ev_wake      (ev_wake)
);

// File: tb/dram_init_cmdgen_tb.sv
module dram_init_cmdgen_tb;

  localparam int CLK_P = 10;
  localparam int HA_W  = 32;
  localparam int ROW_W = 14;
  localparam int RANKS = 2;
  localparam int NOPS  = 5;

  typedef struct {
    logic [3:0]       pins;
    logic [ROW_W-1:0] addr;
    logic [1:0]       ba;
    logic             fwd;
    logic [HA_W-1:0]  ha;
    string            req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [2:0] mode_rd;
  logic [1:0] strap_type = 2'b10;
  logic [1:0] mem_type;
  logic host_req = 1'b0;
  logic [HA_W-1:0] host_addr = '0;
  logic host_ack;
  logic fwd_req;
  logic [HA_W-1:0] fwd_addr;
  logic fwd_ack = 1'b0;
  logic lp_req = 1'b0;
  logic pend_busy = 1'b0;
  logic [RANKS-1:0] dram_cke;
  logic cs_n, ras_n, cas_n, we_n;
  logic [ROW_W-1:0] dram_addr;
  logic [1:0] dram_ba;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  dram_init_cmdgen #(.HA_W(HA_W), .ROW_W(ROW_W), .RANKS(RANKS), .EXIT_NOPS(NOPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .mode_rd(mode_rd),
    .strap_type(strap_type), .mem_type(mem_type), .host_req(host_req), .host_addr(host_addr),
    .host_ack(host_ack), .fwd_req(fwd_req), .fwd_addr(fwd_addr), .fwd_ack(fwd_ack),
    .lp_req(lp_req), .pend_busy(pend_busy), .dram_cke(dram_cke), .dram_cs_n(cs_n),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_addr(dram_addr),
    .dram_ba(dram_ba)
  );

  function automatic logic [3:0] pins_now();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected result of one host access, written from the requirement text.
  function automatic exp_t predict(input logic [2:0] m, input logic [HA_W-1:0] ha);
    exp_t e;
    e.pins = 4'b0111; e.addr = '0; e.ba = 2'b00; e.fwd = 1'b0; e.ha = ha;
    e.req = "R7";
    case (m)
      3'd1: e.req = "R3";
      3'd2: begin e.req = "R4"; e.pins = 4'b0010; e.addr = 14'h0400; end
      3'd3: begin
        e.req = "R5"; e.pins = 4'b0000;
        for (int i = 0; i < 10; i++) e.addr[i] = ha[i+3];
        e.addr[11] = ha[13];
        e.ba = {ha[15], ha[14]};
      end
      3'd6: begin e.req = "R6"; e.pins = 4'b0001; end
      3'd7: begin e.req = "R8"; e.fwd = 1'b1; end
      default: ;
    endcase
    return e;
  endfunction

  // Monitor: pop one expected item for every acknowledge.
  always @(negedge clk) begin
    if (rst_n && host_ack) begin
      if (sb.size() == 0) chk(1'b0, "R3 unexpected ack", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(pins_now() == e.pins, e.req, pins_now(), e.pins);
        chk(dram_addr == e.addr, e.req, dram_addr, e.addr);
        chk(dram_ba == e.ba, e.req, dram_ba, e.ba);
        if (e.fwd) chk(fwd_req && fwd_addr == e.ha, "R8 fwd", fwd_addr, e.ha);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #(CLK_P/4);
  endtask

  task automatic set_mode(input logic [2:0] m);
    step();
    cfg_wr = 1'b1; cfg_wdata = m;
    step();
    cfg_wr = 1'b0;
    chk(mode_rd == m, "R12", mode_rd, m);
  endtask

  task automatic access(input logic [HA_W-1:0] ha);
    int n;
    sb.push_back(predict(mode_rd, ha));
    step();
    host_addr = ha; host_req = 1'b1; fwd_ack = (mode_rd == 3'd7);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!host_ack && n < 20);
    #(CLK_P/4);
    host_req = 1'b0; fwd_ack = 1'b0;
    chk(n == 1, "R3 ack latency", n, 1);
    step();
    chk(!host_ack, "R3 single ack", host_ack, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(dram_cke == '0, "R1 cke in reset", dram_cke, 0);
    #(CLK_P/4); rst_n = 1'b1;
    @(negedge clk);
    chk(mode_rd == 3'd0, "R1 mode", mode_rd, 0);
    chk(dram_cke == '0, "R1 cke", dram_cke, 0);
    chk(pins_now() == 4'b0111, "R1 idle pins", pins_now(), 4'b0111);
    chk(!host_ack, "R1 ack", host_ack, 0);
    chk(mem_type == 2'b10, "R9 ddr2", mem_type, 2'b10);
    step(); strap_type = 2'b01;
    @(negedge clk);
    chk(mem_type == 2'b01, "R9 reserved", mem_type, 2'b01);

    access(32'h0000_1238);                // mode 000: R7
    chk(dram_cke == '0, "R2 still low", dram_cke, 0);
    set_mode(3'd1);
    chk(dram_cke == '1, "R2 all high", dram_cke, '1);
    access(32'h0000_0040);                // R3
    set_mode(3'd2); access(32'h0000_FFF8);  // R4
    set_mode(3'd3);
    access(32'h0000_6AB8);                // R5
    access(32'h0000_9FF8);                // R5 other pattern
    set_mode(3'd6); access(32'h0000_0100); // R6
    set_mode(3'd5); access(32'h0000_0008); // R7
    set_mode(3'd4); access(32'h0000_0010); // R7
    set_mode(3'd0);
    chk(dram_cke == '1, "R2 stays high", dram_cke, '1);
    access(32'h0000_0018);                // R7
    set_mode(3'd7);
    access(32'hA5A5_1234);                // R8
    step(); host_req = 1'b1; host_addr = 32'h77;
    @(negedge clk);
    chk(fwd_req && !host_ack, "R8 waits downstream", host_ack, 0);
    #(CLK_P/4); host_req = 1'b0;

    // Low-power entry with traffic pending.
    step(); lp_req = 1'b1; pend_busy = 1'b1;
    repeat (3) @(negedge clk);
    chk(dram_cke == '1 && pins_now() == 4'b0111, "R10 drain", dram_cke, '1);
    #(CLK_P/4); pend_busy = 1'b0;
    @(negedge clk);
    chk(pins_now() == 4'b0001, "R10 refresh", pins_now(), 4'b0001);
    chk(dram_cke == '0, "R10 cke low", dram_cke, 0);
    @(negedge clk);
    chk(pins_now() == 4'b0111 && dram_cke == '0, "R10 asleep", dram_cke, 0);
    #(CLK_P/4);
    sb.push_back(predict(3'd7, 32'h0000_0C00));
    host_addr = 32'h0000_0C00; host_req = 1'b1; fwd_ack = 1'b1;
    repeat (3) @(negedge clk);
    chk(!host_ack && !fwd_req, "R10 host held", host_ack, 0);
    #(CLK_P/4); lp_req = 1'b0;
    begin
      int k;
      k = 0;
      do begin
        @(negedge clk);
        k++;
        if (!host_ack) chk(dram_cke == '1 && pins_now() == 4'b0111, "R11 wake nop", dram_cke, '1);
      end while (!host_ack && k < 40);
      chk(k == NOPS + 1, "R11 wake length", k, NOPS + 1);
    end
    #(CLK_P/4); host_req = 1'b0; fwd_ack = 1'b0;

    // Resume from suspend: reset again.
    step(); rst_n = 1'b0;
    @(negedge clk);
    chk(dram_cke == '0 && mode_rd == 3'd0, "R1 re-reset", dram_cke, 0);
    #(CLK_P/4); rst_n = 1'b1;
    @(negedge clk);
    chk(dram_cke == '0, "R2 after resume", dram_cke, 0);
    access(32'h0000_0020);                // R7 in mode 000
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R3 scoreboard empty", sb.size(), 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule